// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block turns the crystal oscillator clock into a slower clock for a host processor. A two-bit select sets the divide ratio to 2, 3, 4 or 5. Every ratio, odd ones included, gives a high phase and a low phase of equal length. For odd ratios a stage clocked on the falling edge adds the missing half cycle to the high phase.

The output is built as a series of periods. Each period is a high phase followed by a low phase. The select, the mute input and the power mode are sampled only on the clock edge that ends a low phase, so a new ratio or a stop never cuts a phase short. Mute forces the output low. The deepest sleep mode (inactive) stops the output in the same way. The receive, active and standby modes let it run. When the output is released, it restarts from count zero with a full low phase before the first rising edge.

The sequencer has three states. IDLE holds the output low. HIGH and LOW time the two phases. The transitions are:
- HIGH to LOW when the high count ends.
- LOW to HIGH when the low count ends and the block is not gated. This also loads the ratio for the next period.
- LOW to IDLE when the low count ends and the block is gated.
- IDLE to LOW when the gate clears. This reloads the ratio and clears the count.

Top module: `clkdiv_mcu_out`

## Requirements
- R1: For an even ratio N (select code c gives N = 2 + c, so code 2'b00 gives 2 and code 2'b10 gives 4), each steady period has a high phase of N half input cycles and a low phase of N half input cycles.
- R2: While reset is asserted the output is low. After release with select 2'b00, the output rises on the 3rd rising clock edge, which is the end of the low phase of the default ratio 5.
- R3: For an odd ratio N (code 2'b01 gives 3, code 2'b11 gives 5), each steady period has a high phase of N half cycles and a low phase of N half cycles, with the extra half cycle added to the high phase.
- R4: When the select changes during a period, that period completes at the old ratio. The next period uses the new ratio in both of its phases.
- R5: Mute (1 = muted), when asserted during a high phase, lets that period finish its full high phase. After that the output stays low for as long as mute is held, whatever the select does.
- R6: A power mode of 2'b11 (inactive) stops the output exactly as mute does. Modes 2'b00, 2'b01 and 2'b10 let it run normally.
- R7: When mute or inactive mode clears, the block loads the current select and restarts from count zero. The output stays low and rises on rising clock edge 1 + ceil(N/2) after the release, then runs normal periods.
- R8: A mute pulse that begins and ends inside a high phase has no effect. The period keeps its N and N half-cycle phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | SEL_W | Divide ratio select, ratio = MIN_DIV + code |
| mute | input | 1 | 1 forces the output low from the next low-phase end |
| pwr_mode | input | 2 | Power mode, 2'b11 = inactive (output stopped) |
| clk_out | output | 1 | Divided clock output |

## Verification
A wrong phase count, a lost ratio load or a stale odd flag shows up at the next edge of clk_out. The high or low phase is then too long or too short when measured in half input cycles, and this is visible within one output period of at most five input cycles. A wrong gate decision shows as one of two faults: a pulse while the output should be muted, or a restart whose first rising edge comes too early or too late. The bench measures every phase at half-cycle resolution. It compares each period with the ratio that was in force when that period started.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_e;

    typedef enum logic [1:0] {
        PM_RX       = 2'b00,
        PM_ACTIVE   = 2'b01,
        PM_STANDBY  = 2'b10,
        PM_INACTIVE = 2'b11
    } pwr_mode_e;

endpackage

// File: rtl/clkdiv_ratio_dec.sv
module clkdiv_ratio_dec #(
    parameter int SEL_W   = 2,
    parameter int MIN_DIV = 2,
    parameter int CNT_W   = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] hi_len,
    output logic [CNT_W-1:0] lo_len,
    output logic             odd
);
    localparam int NUM = 1 << SEL_W;

    logic [CNT_W-1:0] hi_tab  [NUM];
    logic [CNT_W-1:0] lo_tab  [NUM];
    logic             odd_tab [NUM];

    // One entry per select code: high phase gets the floor half,
    // low phase the ceiling half of the ratio (in whole input cycles).
    for (genvar g = 0; g < NUM; g++) begin : g_tab
        localparam int DIV = MIN_DIV + g;
        assign hi_tab[g]  = CNT_W'(DIV / 2);
        assign lo_tab[g]  = CNT_W'(DIV - DIV / 2);
        assign odd_tab[g] = ((DIV % 2) == 1);
    end

    assign hi_len = hi_tab[sel];
    assign lo_len = lo_tab[sel];
    assign odd    = odd_tab[sel];

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int       CNT_W   = 3,
    parameter bit [7:0] RST_HI  = 8'd2,
    parameter bit [7:0] RST_LO  = 8'd3,
    parameter bit       RST_ODD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic [CNT_W-1:0] new_hi,
    input  logic [CNT_W-1:0] new_lo,
    input  logic             new_odd,
    output logic             pos_hi,
    output logic             odd_q
);
    div_state_e       state_q, state_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [CNT_W-1:0] hi_q, hi_nxt;
    logic [CNT_W-1:0] lo_q, lo_nxt;
    logic             odd_nxt;
    logic             high_done, low_done;

    assign high_done = (cnt_q == hi_q - 1'b1);
    assign low_done  = (cnt_q == lo_q - 1'b1);

    // Next-state logic: lengths load only at a low-phase end or on restart.
    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        hi_nxt    = hi_q;
        lo_nxt    = lo_q;
        odd_nxt   = odd_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!gate) begin
                    state_nxt = ST_LOW;
                    cnt_nxt   = '0;
                    hi_nxt    = new_hi;
                    lo_nxt    = new_lo;
                    odd_nxt   = new_odd;
                end
            end
            ST_HIGH: begin
                if (high_done) begin
                    state_nxt = ST_LOW;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            ST_LOW: begin
                if (low_done) begin
                    cnt_nxt = '0;
                    if (gate) begin
                        state_nxt = ST_IDLE;
                    end else begin
                        state_nxt = ST_HIGH;
                        hi_nxt    = new_hi;
                        lo_nxt    = new_lo;
                        odd_nxt   = new_odd;
                    end
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
            cnt_q   <= '0;
            hi_q    <= CNT_W'(RST_HI);
            lo_q    <= CNT_W'(RST_LO);
            odd_q   <= RST_ODD;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
            hi_q    <= hi_nxt;
            lo_q    <= lo_nxt;
            odd_q   <= odd_nxt;
        end
    end

    // Output register: glitch-free high flag from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_hi <= 1'b0;
        end else begin
            pos_hi <= (state_nxt == ST_HIGH);
        end
    end

    // R1: the phase counter never passes the length of its phase
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (cnt_q < ((state_q == ST_HIGH) ? hi_q : lo_q)));

    // R4: lengths change only after a completed low phase or from IDLE
    a_r4_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_q != $past(hi_q)) || (lo_q != $past(lo_q))) |->
        (($past(state_q) == ST_IDLE) || (($past(state_q) == ST_LOW) && $past(low_done))));

    // R5: gate seen at a low-phase end stops the output
    a_r5_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOW) && low_done && gate) |=> (state_q == ST_IDLE) && !pos_hi);

    // R7: release restarts at count zero with the output low
    a_r7_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !gate) |=> ((state_q == ST_LOW) && (cnt_q == '0) && !pos_hi));

    // R8: no stop anywhere except at a low-phase end
    a_r8_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HIGH) || ((state_q == ST_LOW) && !low_done)) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/clkdiv_half_stretch.sv
module clkdiv_half_stretch #(
    parameter bit ALLOW_ODD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_hi,
    input  logic odd_q,
    output logic clk_out
);
    logic neg_hi;

    // Falling-edge copy of the high flag, half a cycle late
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_hi <= 1'b0;
        end else begin
            neg_hi <= pos_hi;
        end
    end

    if (ALLOW_ODD) begin : g_odd
        assign clk_out = pos_hi | (odd_q & neg_hi);
    end else begin : g_even
        assign clk_out = pos_hi;
    end

    // R3: the stretch only extends a high phase, never starts one
    a_r3_stretch_tail: assert property (@(negedge clk) disable iff (!rst_n)
        (neg_hi && !$past(neg_hi)) |-> $past(pos_hi));

endmodule

// File: rtl/clkdiv_mcu_out.sv
module clkdiv_mcu_out
    import clkdiv_pkg::*;
#(
    parameter int SEL_W   = 2,
    parameter int MIN_DIV = 2,
    parameter int RST_SEL = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             mute,
    input  logic [1:0]       pwr_mode,
    output logic             clk_out
);
    localparam int MAX_DIV   = MIN_DIV + (1 << SEL_W) - 1;
    localparam int CNT_W     = $clog2(MAX_DIV + 1);
    localparam int RST_DIV   = MIN_DIV + RST_SEL;
    localparam bit ALLOW_ODD = ((1 << SEL_W) > 1) || ((MIN_DIV % 2) == 1);

    logic [CNT_W-1:0] dec_hi, dec_lo;
    logic             dec_odd;
    logic             gate;
    logic             pos_hi, odd_q;

    assign gate = mute | (pwr_mode == PM_INACTIVE);

    clkdiv_ratio_dec #(
        .SEL_W  (SEL_W),
        .MIN_DIV(MIN_DIV),
        .CNT_W  (CNT_W)
    ) u_dec (
        .sel   (div_sel),
        .hi_len(dec_hi),
        .lo_len(dec_lo),
        .odd   (dec_odd)
    );

    clkdiv_seq #(
        .CNT_W  (CNT_W),
        .RST_HI (8'(RST_DIV / 2)),
        .RST_LO (8'(RST_DIV - RST_DIV / 2)),
        .RST_ODD((RST_DIV % 2) == 1)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate   (gate),
        .new_hi (dec_hi),
        .new_lo (dec_lo),
        .new_odd(dec_odd),
        .pos_hi (pos_hi),
        .odd_q  (odd_q)
    );

    clkdiv_half_stretch #(
        .ALLOW_ODD(ALLOW_ODD)
    ) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .pos_hi (pos_hi),
        .odd_q  (odd_q),
        .clk_out(clk_out)
    );

    // R6: inactive mode at a low-phase end stops the sequencer
    a_r6_inactive_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_mode == PM_INACTIVE) && (u_seq.state_q == ST_LOW) && u_seq.low_done)
        |=> (u_seq.state_q == ST_IDLE));

endmodule

// File: tb/sim_clkdiv_mcu_out.sv
module sim_clkdiv_mcu_out;

    typedef struct {
        int    hi;
        int    lo;
        bit    lo_dc;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       mute = 1'b0;
    logic [1:0] pwr_mode = 2'b00;
    logic       clk_out;

    int   errors = 0;
    int   checks = 0;
    int   cur_n = 2;
    exp_t q[$];
    bit   quiet = 1'b0;
    int   quiet_hits = 0;
    bit   done = 1'b0;

    bit   m_prev = 1'b0;
    bit   m_armed = 1'b0;
    int   m_hi_cnt = 0;
    int   m_lo_cnt = 0;
    int   m_hi_len = 0;

    clkdiv_mcu_out u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .mute    (mute),
        .pwr_mode(pwr_mode),
        .clk_out (clk_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic string tag_of(input int n);
        return ((n % 2) == 1) ? "R3" : "R1";
    endfunction

    task automatic push(input int n, input bit dc, input string tag);
        exp_t e;
        e.hi = n;
        e.lo = n;
        e.lo_dc = dc;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: samples mid half-cycle, measures phases in half cycles
    initial begin
        exp_t e;
        bit   s;
        forever begin
            @(clk);
            #5;
            s = (clk_out === 1'b1);
            if (quiet && s) quiet_hits++;
            if (!rst_n) begin
                m_prev = 1'b0;
                m_armed = 1'b0;
                m_hi_cnt = 0;
                m_lo_cnt = 0;
            end else begin
                if (s == m_prev) begin
                    if (s) m_hi_cnt++;
                    else m_lo_cnt++;
                end else if (!s) begin
                    m_hi_len = m_hi_cnt;
                    m_lo_cnt = 1;
                end else begin
                    if (m_armed) begin
                        if (q.size() == 0) begin
                            check("scoreboard empty", 1, 0);
                        end else begin
                            e = q.pop_front();
                            check({e.tag, " high"}, m_hi_len, e.hi);
                            if (!e.lo_dc) check({e.tag, " low"}, m_lo_cnt, e.lo);
                        end
                    end
                    m_armed = 1'b1;
                    m_hi_cnt = 1;
                end
                m_prev = s;
            end
        end
    end

    // Driver: change the select at a rising edge, push one item per period
    task automatic periods(input logic [1:0] code, input int n, input string tg);
        bit changed;
        @(posedge clk_out);
        #1;
        changed = ((2 + int'(code)) != cur_n);
        div_sel = code;
        push(cur_n, 1'b0, (tg != "") ? tg : tag_of(cur_n));
        cur_n = 2 + int'(code);
        for (int i = 1; i < n; i++) begin
            @(posedge clk_out);
            #1;
            push(cur_n, 1'b0, (tg != "") ? tg : ((i == 1 && changed) ? "R4" : tag_of(cur_n)));
        end
    endtask

    task automatic quiet_window(input string tag, input int cycles);
        quiet_hits = 0;
        quiet = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            div_sel = 2'(i % 4);
        end
        quiet = 1'b0;
        check(tag, quiet_hits, 0);
    endtask

    task automatic stop_and_restart(input bit use_mode, input logic [1:0] code, input string tag);
        int n;
        @(posedge clk_out);
        #1;
        if (use_mode) pwr_mode = 2'b11;
        else mute = 1'b1;
        push(cur_n, 1'b1, tag);
        repeat (cur_n + 2) @(posedge clk);
        quiet_window(tag, 40);
        div_sel = code;
        @(negedge clk);
        if (use_mode) pwr_mode = 2'b01;
        else mute = 1'b0;
        n = 0;
        do begin
            @(posedge clk);
            #5;
            n++;
        end while (clk_out !== 1'b1 && n < 20);
        check("R7 restart edge", n, 1 + (2 + int'(code) + 1) / 2);
        cur_n = 2 + int'(code);
        push(cur_n, 1'b0, "R7");
    endtask

    initial begin
        int n;
        #35;
        check("R2 reset output", int'(clk_out === 1'b1), 0);
        @(negedge clk);
        #2;
        rst_n = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            #5;
            n++;
        end while (clk_out !== 1'b1 && n < 20);
        check("R2 default ratio low phase", n, 3);
        cur_n = 2;
        push(cur_n, 1'b0, "R1");

        periods(2'b00, 4, "");
        periods(2'b01, 5, "");
        periods(2'b10, 4, "");
        periods(2'b11, 4, "");
        periods(2'b00, 3, "");
        periods(2'b11, 3, "");

        stop_and_restart(1'b0, 2'b01, "R5");
        periods(2'b01, 3, "");

        pwr_mode = 2'b10;
        periods(2'b10, 3, "R6");
        pwr_mode = 2'b01;
        periods(2'b10, 3, "R6");
        stop_and_restart(1'b1, 2'b11, "R6");
        periods(2'b11, 2, "");

        @(posedge clk_out);
        #1;
        push(cur_n, 1'b0, "R8");
        mute = 1'b1;
        @(posedge clk);
        #1;
        mute = 1'b0;
        periods(2'b11, 3, "");
        periods(2'b10, 2, "");

        repeat (4) @(posedge clk);
        finish_run();
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule